// File: doc/BRIEF.md
# Boot Hold-Off Sequencer

This block decides the cycle in which a processor core may begin fetching after reset. While reset is asserted it samples three mode pins and keeps the resulting boot mode until the next reset. The mode selects one of three release rules. In byte-memory boot, the DMA engine writes an initial burst of program words, and the core is held until the whole burst has arrived. In host-port boot, an external host may write any amount of program memory, and the core is held until that host writes program address zero. In every other mode the core runs at once.

The block watches the program-memory write strobe and its address. It drives a registered run enable and a constant start address of zero. The DMA engines and the memories are outside it. After release, further writes have no effect until the next reset.

Top module: `boot_holdoff_seq`

## Requirements
- R1: The boot mode is taken from `mode_pins` (bit order {C,B,A}) at the last rising clock edge with `rst` high. Later changes on the pins have no effect until the next reset.
- R2: `core_run` is low at every clock edge where `rst` is high.
- R3: In byte boot (mode pins 3'b000), `core_run` stays low while fewer than `BURST_WORDS` (default 32) write strobes have been seen since reset.
- R4: In byte boot, `core_run` is high after the clock edge that accepts the `BURST_WORDS`-th write strobe.
- R5: In host boot (mode pins 3'b101), a write to any non-zero address leaves `core_run` low, however many such writes occur.
- R6: In host boot, `core_run` is high after the clock edge that accepts a write with `pm_addr` equal to 0.
- R7: In any mode other than 3'b000 and 3'b101, `core_run` is high after the first clock edge with `rst` low.
- R8: Once high, `core_run` stays high until reset, whatever the writes or pins do.
- R9: `start_addr` is always zero.
- R10: In byte boot, every write counts toward the burst whatever its address, and a write to address 0 does not release the core early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the mode pins are sampled while it is high |
| mode_pins | input | 3 | Boot mode straps {C,B,A} |
| pm_wr | input | 1 | Program-memory write strobe |
| pm_addr | input | ADDR_W | Program-memory write address |
| core_run | output | 1 | Registered core run enable |
| start_addr | output | ADDR_W | Fetch start address, always zero |

## Verification
Byte boot is driven with 31 writes that include address 0, then with the 32nd write. This separates a true burst count from an off-by-one count and from an early release on an address-zero match. Host boot receives a long run of non-zero writes before the address-zero write, which tells a host-address release apart from any count. A free mode whose pins were changed during reset shows that the last reset-cycle value is the one latched, and pin changes made after reset show that the latched mode does not follow the pins. A reset asserted while the core is running confirms that the run enable drops again.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    BOOT_FREE = 2'd0,
    BOOT_BYTE = 2'd1,
    BOOT_HOST = 2'd2
  } boot_mode_e;
endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_seq_pkg::*;
#(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] BYTE_CODE = 3'b000,
  parameter logic [MODE_W-1:0] HOST_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_pins,
  output boot_mode_e        boot_mode
);

  boot_mode_e decoded;

  always_comb begin
    if (mode_pins == HOST_CODE)      decoded = BOOT_HOST;
    else if (mode_pins == BYTE_CODE) decoded = BOOT_BYTE;
    else                             decoded = BOOT_FREE;
  end

  // Sampled on every reset edge; the last one before release wins.
  always_ff @(posedge clk) begin
    if (rst) boot_mode <= decoded;
  end

  // R1: mode frozen once out of reset
  a_r1_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(boot_mode));

endmodule

// File: rtl/boot_burst_counter.sv
module boot_burst_counter #(
  parameter int BURST_WORDS = 32,
  localparam int CNT_W = $clog2(BURST_WORDS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic wr_stb,
  output logic burst_last
);

  logic [CNT_W-1:0] cnt;

  assign burst_last = en && wr_stb && (cnt == CNT_W'(BURST_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (en && wr_stb) cnt <= cnt + 1'b1;
  end

  // R3: count never runs past the burst length
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(BURST_WORDS));

endmodule

// File: rtl/boot_host_release.sv
module boot_host_release #(
  parameter int ADDR_W = 14
) (
  input  logic              en,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              host_hit
);

  assign host_hit = en && wr_stb && (wr_addr == '0);

endmodule

// File: rtl/boot_holdoff_seq.sv
module boot_holdoff_seq
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BURST_WORDS = 32,
  parameter int MODE_W      = 3,
  parameter logic [MODE_W-1:0] BYTE_CODE = 3'b000,
  parameter logic [MODE_W-1:0] HOST_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_pins,
  input  logic              pm_wr,
  input  logic [ADDR_W-1:0] pm_addr,
  output logic              core_run,
  output logic [ADDR_W-1:0] start_addr
);

  boot_mode_e boot_mode;
  logic       byte_en, host_en;
  logic       burst_last, host_hit;

  boot_mode_latch #(
    .MODE_W(MODE_W), .BYTE_CODE(BYTE_CODE), .HOST_CODE(HOST_CODE)
  ) u_mode (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .boot_mode(boot_mode)
  );

  assign byte_en = !core_run && (boot_mode == BOOT_BYTE);
  assign host_en = !core_run && (boot_mode == BOOT_HOST);

  boot_burst_counter #(.BURST_WORDS(BURST_WORDS)) u_burst (
    .clk(clk), .rst(rst), .en(byte_en), .wr_stb(pm_wr),
    .burst_last(burst_last)
  );

  boot_host_release #(.ADDR_W(ADDR_W)) u_host (
    .en(host_en), .wr_stb(pm_wr), .wr_addr(pm_addr), .host_hit(host_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run <= 1'b0;
    end else if (!core_run) begin
      unique case (boot_mode)
        BOOT_BYTE: core_run <= burst_last;
        BOOT_HOST: core_run <= host_hit;
        default:   core_run <= 1'b1;
      endcase
    end
  end

  assign start_addr = '0;

  // R2: run enable cleared by reset
  a_r2_reset_low: assert property (@(posedge clk)
    rst |=> !core_run);

  // R8: sticky once released
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    core_run |=> core_run);

  // R6: host address-zero write releases
  a_r6_host_release: assert property (@(posedge clk) disable iff (rst)
    (boot_mode == BOOT_HOST && pm_wr && pm_addr == '0) |=> core_run);

  // R5: nothing but an address-zero write releases host boot
  a_r5_host_hold: assert property (@(posedge clk) disable iff (rst)
    (boot_mode == BOOT_HOST && !core_run && !(pm_wr && pm_addr == '0))
      |=> !core_run);

  // R7: free modes release at once
  a_r7_free_run: assert property (@(posedge clk) disable iff (rst)
    (boot_mode == BOOT_FREE) |=> core_run);

  // R3: byte boot holds without a final burst write
  a_r3_byte_hold: assert property (@(posedge clk) disable iff (rst)
    (boot_mode == BOOT_BYTE && !core_run && !burst_last) |=> !core_run);

endmodule

// File: tb/boot_holdoff_seq_tb.sv
`timescale 1ns/1ps
module boot_holdoff_seq_tb;
  localparam int ADDR_W = 14;
  localparam int BURST  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        mode_pins = 3'b000;
  logic              pm_wr = 1'b0;
  logic [ADDR_W-1:0] pm_addr = '0;
  logic              core_run;
  logic [ADDR_W-1:0] start_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit    exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  boot_holdoff_seq #(.ADDR_W(ADDR_W), .BURST_WORDS(BURST)) u_dut (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .pm_wr(pm_wr),
    .pm_addr(pm_addr), .core_run(core_run), .start_addr(start_addr)
  );

  // driver: apply one cycle of stimulus and queue the expected run enable
  task automatic cyc(input logic r, input logic [2:0] m, input logic w,
                     input logic [ADDR_W-1:0] a, input bit e, input string tag);
    @(negedge clk);
    rst = r; mode_pins = m; pm_wr = w; pm_addr = a;
    exp_q.push_back(e);
    req_q.push_back(tag);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = req_q.pop_front();
      checks++;
      if (core_run !== e) begin
        errors++;
        $display("FAIL %s core_run actual=%0b expected=%0b", t, core_run, e);
      end
      checks++;
      if (start_addr !== '0) begin
        errors++;
        $display("FAIL R9 start_addr actual=%0h expected=0", start_addr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // byte boot
    for (int i = 0; i < 3; i++) cyc(1, 3'b000, 0, '0, 0, "R2");
    // pins change after reset: R1
    for (int i = 0; i < BURST - 1; i++)
      cyc(0, 3'b111, 1, (i % 4 == 0) ? '0 : ADDR_W'(i * 3), 0, "R3_R10_R1");
    cyc(0, 3'b101, 0, '0, 0, "R3");
    cyc(0, 3'b101, 1, ADDR_W'(77), 1, "R4");
    for (int i = 0; i < 4; i++) cyc(0, 3'b000, i[0], '0, 1, "R8");
    // reset while running
    cyc(1, 3'b101, 0, '0, 0, "R2");
    cyc(1, 3'b101, 0, '0, 0, "R2");
    // host boot, many non-zero writes
    for (int i = 0; i < 40; i++)
      cyc(0, (i > 20) ? 3'b000 : 3'b101, 1, ADDR_W'(i + 1), 0, "R5_R1");
    cyc(0, 3'b000, 0, '0, 0, "R5");
    cyc(0, 3'b000, 1, '0, 1, "R6");
    for (int i = 0; i < 3; i++) cyc(0, 3'b101, 1, ADDR_W'(i), 1, "R8");
    // free mode: last reset-cycle pins win
    cyc(1, 3'b101, 0, '0, 0, "R2");
    cyc(1, 3'b011, 0, '0, 0, "R2");
    cyc(0, 3'b000, 0, '0, 1, "R7_R1");
    cyc(0, 3'b000, 0, '0, 1, "R8");
    // host mode latched at last reset cycle after a free value
    cyc(1, 3'b010, 0, '0, 0, "R2");
    cyc(1, 3'b101, 0, '0, 0, "R2");
    cyc(0, 3'b010, 0, '0, 0, "R1_R5");
    cyc(0, 3'b010, 1, '0, 1, "R6");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule